// File: doc/BRIEF.md
# H-Bridge Command Decoder with Fixed Off-Time Current Chopping

This block turns two host control bits into a drive state for each of the two legs of an H-bridge. Each leg has a high-side enable request, a low-side enable request and a tri-state flag. The host selects the meaning of the two bits with a style input. In phase/enable style, `ctl_a` is the phase and `ctl_b` is the enable. In two-input PWM style, `ctl_a` is input 1 and `ctl_b` is input 2. A half-bridge mode drives only leg 2 and leaves leg 1 floating.

A peak-current chopper sits between the decoded command and the legs. When forward, reverse or half-bridge drive starts, the digital current-threshold input is ignored for a blanking window. After that window, a trip forces both low sides on for a fixed off time. Drive then resumes with a fresh blanking window. The active-low `chop_n` output goes low only during this internally forced brake. A regulation-disable input stops new chops from starting. A sleep input floats every leg. All outputs are registered, so they follow the inputs sampled at the previous rising edge.

Top module: `hbridge_chop_ctrl`

## Requirements
- R1: While `sleep` is 1, every leg reports tri-state with both enables 0 one cycle later, and `chop_n` is 1, whatever the other inputs are.
- R2: In phase/enable style (`style_pwm`=0, `half_mode`=0), `ctl_b`=0 puts both legs low-side on (brake). With `ctl_b`=1, `ctl_a`=1 gives leg 1 high and leg 2 low (forward), and `ctl_a`=0 gives leg 1 low and leg 2 high (reverse).
- R3: In two-input style (`style_pwm`=1, `half_mode`=0), {`ctl_a`,`ctl_b`} behaves as follows: 00 floats both legs (coast), 10 is forward, 01 is reverse, and 11 turns both low sides on.
- R4: With `half_mode`=1, leg 1 is always tri-state. In phase/enable style, enable 0 gives leg 2 low, and enable 1 with phase 0 gives leg 2 high. In two-input style, 00 floats leg 2, 01 gives leg 2 high and 11 gives leg 2 low. The invalid codes (phase/enable 1/1, or two-input 10) set `invalid_cmd` and float leg 2.
- R5: For BLANK_CYC cycles after drive starts, `ithr_trip` is ignored. A trip held from the start shows as a chop on the output two cycles after the window ends (the BLANK_CYC+2nd output cycle).
- R6: A trip after blanking puts both legs (leg 2 only in half mode) low-side on for exactly OFF_CYC output cycles. The commanded drive then returns with a new blanking window.
- R7: `chop_n` is 0 only during a forced brake. It stays 1 during a brake that the host commands.
- R8: While `reg_disable` is 1, no chop starts.
- R9: If the commanded direction changes during an off time, the chop ends at the next output cycle and blanking restarts for the new direction.
- R10: No leg ever asserts its high-side and low-side enables together.
- R11: Reset floats both legs, releases `chop_n` and clears `invalid_cmd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep | input | 1 | 1 floats the whole bridge |
| style_pwm | input | 1 | 0 = phase/enable style, 1 = two-input style |
| half_mode | input | 1 | 1 = only leg 2 is driven |
| ctl_a | input | 1 | Phase (phase/enable style) or input 1 (two-input style) |
| ctl_b | input | 1 | Enable (phase/enable style) or input 2 (two-input style) |
| reg_disable | input | 1 | 1 = current regulation off |
| ithr_trip | input | 1 | Current-threshold comparator result |
| leg1_hs | output | 1 | Leg 1 high-side enable request |
| leg1_ls | output | 1 | Leg 1 low-side enable request |
| leg1_hiz | output | 1 | Leg 1 tri-state |
| leg2_hs | output | 1 | Leg 2 high-side enable request |
| leg2_ls | output | 1 | Leg 2 low-side enable request |
| leg2_hiz | output | 1 | Leg 2 tri-state |
| chop_n | output | 1 | 0 during an internally forced brake |
| invalid_cmd | output | 1 | Half-bridge invalid code was seen |

## Verification
The bench holds the trip input high from the first drive cycle, which targets the edge of the blanking window. A design with an off-by-one counter chops one cycle early or late. A design without blanking chops at once. The bench then counts the brake length to the cycle and checks that drive resumes. A counter that reloads wrongly lengthens or shortens the brake, or never releases it.

A phase flip during the off time checks that the chop is cancelled and that the new direction gets its own full blanking window. A design that kept the old chop would brake while reverse drive is commanded. Other bench cases catch further faults:
- Host-commanded brake with the trip high: a design that mixed up host brake and forced brake would pull `chop_n` low here.
- Regulation disabled: a design that ignored the disable would chop.
- The invalid half-bridge codes: a faulty design would drive leg 2 high.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
  typedef enum logic [1:0] {
    LEG_OFF  = 2'd0,
    LEG_HIGH = 2'd1,
    LEG_LOW  = 2'd2
  } leg_e;

  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_FWD  = 2'd1,
    DIR_REV  = 2'd2,
    DIR_HALF = 2'd3
  } dir_e;

  typedef struct packed {
    leg_e leg1;
    leg_e leg2;
    dir_e dir;
    logic half;
    logic invalid;
  } cmd_t;

  localparam int NUM_LEGS = 2;

  localparam cmd_t CMD_FLOAT = '{leg1: LEG_OFF, leg2: LEG_OFF, dir: DIR_NONE,
                                 half: 1'b0, invalid: 1'b0};
endpackage

// File: rtl/hbc_cmd_decode.sv
module hbc_cmd_decode
  import hbc_pkg::*;
(
  input  logic sleep,
  input  logic style_pwm,
  input  logic half_mode,
  input  logic ctl_a,
  input  logic ctl_b,
  output cmd_t cmd
);
  always_comb begin
    cmd      = CMD_FLOAT;
    cmd.half = half_mode;
    if (!sleep) begin
      unique case ({half_mode, style_pwm})
        2'b00: begin // phase/enable, full bridge
          if (!ctl_b) begin
            cmd.leg1 = LEG_LOW;
            cmd.leg2 = LEG_LOW;
          end else if (ctl_a) begin
            cmd.leg1 = LEG_HIGH;
            cmd.leg2 = LEG_LOW;
            cmd.dir  = DIR_FWD;
          end else begin
            cmd.leg1 = LEG_LOW;
            cmd.leg2 = LEG_HIGH;
            cmd.dir  = DIR_REV;
          end
        end
        2'b01: begin // two-input, full bridge
          unique case ({ctl_a, ctl_b})
            2'b00: ;
            2'b10: begin
              cmd.leg1 = LEG_HIGH;
              cmd.leg2 = LEG_LOW;
              cmd.dir  = DIR_FWD;
            end
            2'b01: begin
              cmd.leg1 = LEG_LOW;
              cmd.leg2 = LEG_HIGH;
              cmd.dir  = DIR_REV;
            end
            default: begin
              cmd.leg1 = LEG_LOW;
              cmd.leg2 = LEG_LOW;
            end
          endcase
        end
        2'b10: begin // phase/enable, half bridge
          if (!ctl_b) begin
            cmd.leg2 = LEG_LOW;
          end else if (!ctl_a) begin
            cmd.leg2 = LEG_HIGH;
            cmd.dir  = DIR_HALF;
          end else begin
            cmd.invalid = 1'b1;
          end
        end
        default: begin // two-input, half bridge
          unique case ({ctl_a, ctl_b})
            2'b00: ;
            2'b01: begin
              cmd.leg2 = LEG_HIGH;
              cmd.dir  = DIR_HALF;
            end
            2'b11: cmd.leg2 = LEG_LOW;
            default: cmd.invalid = 1'b1;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/hbc_chop_fsm.sv
module hbc_chop_fsm
  import hbc_pkg::*;
#(
  parameter int BLANK_CYC = 250,
  parameter int OFF_CYC   = 3125
) (
  input  logic clk,
  input  logic rst_n,
  input  dir_e new_dir,
  input  dir_e cur_dir,
  input  logic trip,
  input  logic reg_dis,
  output logic forced
);
  localparam int CNT_MAX = (BLANK_CYC > OFF_CYC) ? BLANK_CYC : OFF_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] BLANK_LAST = CW'(BLANK_CYC - 1);
  localparam logic [CW-1:0] OFF_LAST   = CW'(OFF_CYC - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_BLANK, ST_SENSE, ST_OFF} chop_st_e;

  chop_st_e      st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (new_dir == DIR_NONE) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (st_q == ST_IDLE || new_dir != cur_dir) begin
      st_q  <= ST_BLANK;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_BLANK: begin
          if (cnt_q == BLANK_LAST) begin
            st_q  <= ST_SENSE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SENSE: begin
          if (trip && !reg_dis) begin
            st_q  <= ST_OFF;
            cnt_q <= '0;
          end
        end
        ST_OFF: begin
          if (cnt_q == OFF_LAST) begin
            st_q  <= ST_BLANK;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          st_q  <= ST_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign forced = (st_q == ST_OFF);
endmodule

// File: rtl/hbc_leg_drive.sv
module hbc_leg_drive
  import hbc_pkg::*;
(
  input  leg_e leg,
  output logic hs,
  output logic ls,
  output logic hiz
);
  always_comb begin
    hs  = 1'b0;
    ls  = 1'b0;
    hiz = 1'b0;
    unique case (leg)
      LEG_HIGH: hs  = 1'b1;
      LEG_LOW:  ls  = 1'b1;
      default:  hiz = 1'b1;
    endcase
  end
endmodule

// File: rtl/hbridge_chop_ctrl.sv
module hbridge_chop_ctrl
  import hbc_pkg::*;
#(
  parameter int BLANK_CYC = 250,
  parameter int OFF_CYC   = 3125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  input  logic style_pwm,
  input  logic half_mode,
  input  logic ctl_a,
  input  logic ctl_b,
  input  logic reg_disable,
  input  logic ithr_trip,
  output logic leg1_hs,
  output logic leg1_ls,
  output logic leg1_hiz,
  output logic leg2_hs,
  output logic leg2_ls,
  output logic leg2_hiz,
  output logic chop_n,
  output logic invalid_cmd
);
  cmd_t cmd_d, cmd_q;
  logic forced;
  leg_e leg_fin [NUM_LEGS];
  logic [NUM_LEGS-1:0] hs_v, ls_v, hiz_v;

  hbc_cmd_decode u_dec (
    .sleep     (sleep),
    .style_pwm (style_pwm),
    .half_mode (half_mode),
    .ctl_a     (ctl_a),
    .ctl_b     (ctl_b),
    .cmd       (cmd_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= CMD_FLOAT;
    else        cmd_q <= cmd_d;
  end

  hbc_chop_fsm #(.BLANK_CYC(BLANK_CYC), .OFF_CYC(OFF_CYC)) u_chop (
    .clk     (clk),
    .rst_n   (rst_n),
    .new_dir (cmd_d.dir),
    .cur_dir (cmd_q.dir),
    .trip    (ithr_trip),
    .reg_dis (reg_disable),
    .forced  (forced)
  );

  // forced brake overrides the commanded legs
  always_comb begin
    leg_fin[0] = cmd_q.leg1;
    leg_fin[1] = cmd_q.leg2;
    if (forced) begin
      leg_fin[0] = cmd_q.half ? LEG_OFF : LEG_LOW;
      leg_fin[1] = LEG_LOW;
    end
  end

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    hbc_leg_drive u_leg (
      .leg (leg_fin[g]),
      .hs  (hs_v[g]),
      .ls  (ls_v[g]),
      .hiz (hiz_v[g])
    );
  end

  assign leg1_hs     = hs_v[0];
  assign leg1_ls     = ls_v[0];
  assign leg1_hiz    = hiz_v[0];
  assign leg2_hs     = hs_v[1];
  assign leg2_ls     = ls_v[1];
  assign leg2_hiz    = hiz_v[1];
  assign chop_n      = ~forced;
  assign invalid_cmd = cmd_q.invalid;
endmodule

// File: rtl/hbc_checker.sv
module hbc_checker (
  input logic clk,
  input logic rst_n,
  input logic sleep,
  input logic reg_disable,
  input logic ithr_trip,
  input logic leg1_hs,
  input logic leg1_ls,
  input logic leg1_hiz,
  input logic leg2_hs,
  input logic leg2_ls,
  input logic leg2_hiz,
  input logic chop_n,
  input logic invalid_cmd
);
  AST_SLEEP_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (leg1_hiz && leg2_hiz && chop_n)); // R1

  AST_NO_SHOOT_LEG1: assert property (@(posedge clk) disable iff (!rst_n)
    !(leg1_hs && leg1_ls)); // R10

  AST_NO_SHOOT_LEG2: assert property (@(posedge clk) disable iff (!rst_n)
    !(leg2_hs && leg2_ls)); // R10

  AST_INVALID_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_cmd |-> (leg1_hiz && leg2_hiz)); // R4

  AST_CHOP_BRAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !chop_n |-> (leg2_ls && !leg1_hs)); // R6

  AST_CHOP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chop_n) |-> $past(ithr_trip && !reg_disable)); // R8
endmodule

bind hbridge_chop_ctrl hbc_checker u_chk (.*);

// File: tb/hbridge_chop_ctrl_bench.sv
module hbridge_chop_ctrl_bench;
  localparam int BLANK = 250;
  localparam int OFFC  = 3125;
  // leg codes {hs,ls,hiz}
  localparam logic [2:0] H = 3'b100, L = 3'b010, Z = 3'b001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sleep = 1'b0, style_pwm = 1'b0, half_mode = 1'b0;
  logic ctl_a = 1'b0, ctl_b = 1'b0, reg_disable = 1'b0, ithr_trip = 1'b0;
  logic leg1_hs, leg1_ls, leg1_hiz, leg2_hs, leg2_ls, leg2_hiz, chop_n, invalid_cmd;
  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  hbridge_chop_ctrl #(.BLANK_CYC(BLANK), .OFF_CYC(OFFC)) u_hbridge_chop_ctrl (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [5:0] legs();
    return {leg1_hs, leg1_ls, leg1_hiz, leg2_hs, leg2_ls, leg2_hiz};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_in(input logic a, input logic b);
    ctl_a = a;
    ctl_b = b;
    step(1);
  endtask

  task automatic neutral();
    sleep = 0; half_mode = 0; style_pwm = 0; reg_disable = 0; ithr_trip = 0;
    set_in(0, 0);
    step(1);
  endtask

  task automatic t_reset();
    step(2);
    chk("R11 legs", legs(), {Z, Z});
    chk("R11 chop_n", chop_n, 1);
    chk("R11 invalid", invalid_cmd, 0);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic t_sleep();
    sleep = 1; style_pwm = 0; ithr_trip = 1;
    set_in(1, 1);
    chk("R1 sleep fwd", legs(), {Z, Z});
    chk("R1 chop_n", chop_n, 1);
    style_pwm = 1;
    set_in(1, 1);
    chk("R1 sleep brake", legs(), {Z, Z});
    neutral();
  endtask

  task automatic t_pe();
    style_pwm = 0;
    set_in(1, 0); chk("R2 brake en0", legs(), {L, L});
    set_in(1, 1); chk("R2 forward", legs(), {H, L});
    set_in(0, 1); chk("R2 reverse", legs(), {L, H});
    neutral();
  endtask

  task automatic t_pwm();
    style_pwm = 1;
    set_in(0, 0); chk("R3 coast", legs(), {Z, Z});
    set_in(1, 0); chk("R3 forward", legs(), {H, L});
    set_in(0, 1); chk("R3 reverse", legs(), {L, H});
    set_in(1, 1); chk("R3 brake", legs(), {L, L});
    neutral();
  endtask

  task automatic t_half();
    half_mode = 1; style_pwm = 0;
    set_in(1, 0); chk("R4 pe low", legs(), {Z, L});
    set_in(0, 1); chk("R4 pe high", legs(), {Z, H});
    set_in(1, 1); chk("R4 pe invalid legs", legs(), {Z, Z});
    chk("R4 pe invalid flag", invalid_cmd, 1);
    style_pwm = 1;
    set_in(0, 0); chk("R4 pwm float", legs(), {Z, Z});
    chk("R4 flag clear", invalid_cmd, 0);
    set_in(0, 1); chk("R4 pwm high", legs(), {Z, H});
    set_in(1, 1); chk("R4 pwm low", legs(), {Z, L});
    set_in(1, 0); chk("R4 pwm invalid legs", legs(), {Z, Z});
    chk("R4 pwm invalid flag", invalid_cmd, 1);
    neutral();
  endtask

  task automatic t_chop();
    logic bad;
    style_pwm = 0; ithr_trip = 1;
    ctl_a = 1; ctl_b = 1;
    bad = 0;
    for (int k = 1; k <= BLANK + 1; k++) begin
      step(1);
      if (legs() !== {H, L} || chop_n !== 1'b1) bad = 1;
    end
    chk("R5 trip ignored in blanking", bad, 0);
    step(1);
    chk("R5 chop after blanking", chop_n, 0);
    chk("R6 brake legs", legs(), {L, L});
    ithr_trip = 0;
    bad = 0;
    for (int k = 1; k < OFFC; k++) begin
      step(1);
      if (legs() !== {L, L} || chop_n !== 1'b0) bad = 1;
    end
    chk("R6 brake held off time", bad, 0);
    step(1);
    chk("R6 drive resumes", legs(), {H, L});
    chk("R6 chop released", chop_n, 1);
    neutral();
  endtask

  task automatic t_host_brake();
    style_pwm = 0; ithr_trip = 1;
    set_in(0, 0);
    step(BLANK + 5);
    chk("R7 host brake legs", legs(), {L, L});
    chk("R7 host brake indicator", chop_n, 1);
    style_pwm = 1;
    set_in(1, 1);
    step(BLANK + 5);
    chk("R7 pwm host brake indicator", chop_n, 1);
    neutral();
  endtask

  task automatic t_regdis();
    style_pwm = 1; reg_disable = 1; ithr_trip = 1;
    set_in(1, 0);
    step(BLANK + 20);
    chk("R8 no chop when disabled", chop_n, 1);
    chk("R8 drive kept", legs(), {H, L});
    neutral();
  endtask

  task automatic t_dirchg();
    style_pwm = 0; ithr_trip = 1;
    ctl_a = 1; ctl_b = 1;
    step(BLANK + 2);
    chk("R9 chop reached", chop_n, 0);
    ctl_a = 0;
    step(1);
    chk("R9 reverse at once", legs(), {L, H});
    chk("R9 chop cancelled", chop_n, 1);
    step(BLANK);
    chk("R9 new blanking", chop_n, 1);
    step(1);
    chk("R9 chop after new blanking", chop_n, 0);
    chk("R10 brake legs no overlap", legs(), {L, L});
    neutral();
  endtask

  task automatic t_half_chop();
    half_mode = 1; style_pwm = 1; ithr_trip = 1;
    ctl_a = 0; ctl_b = 1;
    step(BLANK + 2);
    chk("R6 half chop legs", legs(), {Z, L});
    chk("R6 half chop indicator", chop_n, 0);
    neutral();
  endtask

  initial begin
    t_reset();
    t_sleep();
    t_pe();
    t_pwm();
    t_half();
    t_chop();
    t_host_brake();
    t_regdis();
    t_dirchg();
    t_half_chop();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule